// File: doc/BRIEF.md
# Boot Source Latch and Code-Window Remapper

This block decides which memory appears at the bottom of the address space after reset, and translates CPU addresses in that low code window to the physical address of the chosen memory. Two boot-select pins are captured a fixed number of clock edges after reset is released. The capture happens again whenever the system leaves standby. Once the pins have been captured, the capture is complete and the block tells the pad logic that the second, shared boot pin is free for general-purpose use.

Software can later write a small remap register that replaces the pin choice. It can select main flash, system memory, SRAM1 or the external memory bank. Only the low window and, in external mode, a second 64 MB window are redirected. Every other address passes through unchanged, so any aliased memory can still be reached at its home address. Accesses that fall past the end of the aliased memory, into the reserved second window, or into the external controller's configuration space while external remap is active are flagged as errors.

Top module: `boot_remap_decoder`

## Requirements
- R1: The pins decode to a 2-bit mode readable on `remap_mode`: pin0=0 gives 00 (main flash) whatever pin1 is; pin1=0 with pin0=1 gives 01 (system memory); pin1=1 with pin0=1 gives 11 (SRAM1). Code 10 is external bank, reachable only through the remap register.
- R2: The pins are captured on the 4th rising clock edge after reset is released. `cpu_ready` is low from reset until that edge and high after it. Later pin changes have no effect on `remap_mode`.
- R3: A cycle with `standby_exit` high drops `cpu_ready` after that edge, and the pins are captured again on the 4th following edge.
- R4: `pin1_released` is low from reset or standby exit until the capture, and high after it.
- R5: A `remap_we` pulse while `cpu_ready` is high loads `remap_wdata` into the mode, which is effective for the transfer in the next cycle. A write while `cpu_ready` is low is ignored.
- R6: Addresses 0x0000_0000–0x03FF_FFFF translate to base + offset. The bases are 0x0800_0000 for mode 00, 0x1FFF_0000 for 01, 0x2000_0000 for 11 and 0x6000_0000 for 10.
- R7: In mode 10, 0x0400_0000–0x07FF_FFFF translates to 0x6400_0000 + offset. In other modes that range passes through untranslated and raises `cpu_err`.
- R8: An alias offset at or beyond the aliased memory size raises `cpu_err`. The sizes are 1 MB for flash, 0x7800 bytes for system memory and 0x1C000 bytes for SRAM1; the external window is never exceeded.
- R9: In mode 10, addresses 0xA000_0000–0xA000_0FFF (external controller configuration) raise `cpu_err`. In other modes they pass without error.
- R10: Every address from 0x0800_0000 upward appears unchanged on `phys_addr`, so remapped memories stay reachable at their own addresses.
- R11: `cpu_err` is high only when `cpu_valid` and `cpu_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin0 | input | 1 | Dedicated boot-select pin |
| boot_pin1 | input | 1 | Shared boot-select pin |
| standby_exit | input | 1 | One-cycle pulse on leaving standby; restarts capture |
| pin1_released | output | 1 | Shared pin no longer needed by this block |
| remap_we | input | 1 | Remap register write strobe |
| remap_wdata | input | 2 | Mode written to the remap register |
| remap_mode | output | 2 | Current mode |
| cpu_valid | input | 1 | CPU transfer present |
| cpu_addr | input | 32 | CPU address |
| cpu_ready | output | 1 | Decoder accepts transfers |
| phys_addr | output | 32 | Translated physical address |
| cpu_err | output | 1 | Error response for the current transfer |

## Verification
A wrong capture counter shows immediately at `cpu_ready`, which rises one edge early or late. A wrong pin decode shows at `remap_mode` on the same edge. A corrupted mode register sends every low-window access to the wrong base, so the very next alias access carries a wrong `phys_addr`. The bench also sweeps each mode over addresses on both sides of each size limit and window edge, where a wrong limit compare flips `cpu_err`.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter int          SAMPLE_EDGE = 4,
  parameter int          WIN_BITS    = 26,
  parameter logic [31:0] FLASH_BASE  = 32'h0800_0000,
  parameter logic [31:0] FLASH_SIZE  = 32'h0010_0000,
  parameter logic [31:0] SYS_BASE    = 32'h1FFF_0000,
  parameter logic [31:0] SYS_SIZE    = 32'h0000_7800,
  parameter logic [31:0] SRAM_BASE   = 32'h2000_0000,
  parameter logic [31:0] SRAM_SIZE   = 32'h0001_C000,
  parameter logic [31:0] EXT1_BASE   = 32'h6000_0000,
  parameter logic [31:0] EXT2_BASE   = 32'h6400_0000,
  parameter logic [31:0] CFG_BASE    = 32'hA000_0000,
  parameter logic [31:0] CFG_SIZE    = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_pin0,
  input  logic        boot_pin1,
  input  logic        standby_exit,
  output logic        pin1_released,
  input  logic        remap_we,
  input  logic [1:0]  remap_wdata,
  output logic [1:0]  remap_mode,
  input  logic        cpu_valid,
  input  logic [31:0] cpu_addr,
  output logic        cpu_ready,
  output logic [31:0] phys_addr,
  output logic        cpu_err
);
  localparam int          CW        = $clog2(SAMPLE_EDGE) + 1;
  localparam logic [CW-1:0] LAST    = CW'(SAMPLE_EDGE - 1);
  localparam logic [31:0] WIN_SPAN  = 32'h1 << WIN_BITS;
  localparam logic [1:0]  M_FLASH   = 2'b00;
  localparam logic [1:0]  M_SYS     = 2'b01;
  localparam logic [1:0]  M_EXT     = 2'b10;
  localparam logic [1:0]  M_SRAM    = 2'b11;

  logic [CW-1:0] cnt;
  logic          latched;
  logic [1:0]    mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      latched <= 1'b0;
      mode    <= M_FLASH;
    end else if (standby_exit) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (!latched) begin
      if (cnt == LAST) begin
        latched <= 1'b1;
        mode    <= {boot_pin1 & boot_pin0, boot_pin0};
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (remap_we) begin
      mode <= remap_wdata;
    end
  end

  assign cpu_ready     = latched;
  assign pin1_released = latched;
  assign remap_mode    = mode;

  logic [31:0] offset, base, limit;
  logic        in_win0, in_win1, in_cfg, bad;

  assign offset  = {{(32-WIN_BITS){1'b0}}, cpu_addr[WIN_BITS-1:0]};
  assign in_win0 = (cpu_addr[31:WIN_BITS] == '0);
  assign in_win1 = (cpu_addr[31:WIN_BITS] == (32-WIN_BITS)'(1));
  assign in_cfg  = (cpu_addr >= CFG_BASE) && (cpu_addr - CFG_BASE < CFG_SIZE);

  always_comb begin
    case (mode)
      M_FLASH: begin base = FLASH_BASE; limit = FLASH_SIZE; end
      M_SYS:   begin base = SYS_BASE;   limit = SYS_SIZE;   end
      M_SRAM:  begin base = SRAM_BASE;  limit = SRAM_SIZE;  end
      default: begin base = EXT1_BASE;  limit = WIN_SPAN;   end
    endcase
  end

  always_comb begin
    phys_addr = cpu_addr;
    bad       = 1'b0;
    if (in_win0) begin
      phys_addr = base + offset;
      bad       = (offset >= limit);
    end else if (in_win1) begin
      if (mode == M_EXT) phys_addr = EXT2_BASE + offset;
      else               bad       = 1'b1;
    end else begin
      bad = (mode == M_EXT) && in_cfg;
    end
  end

  assign cpu_err = cpu_valid & latched & bad;

  a_r2_ready_on_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ready) |-> $past(cnt) == LAST);
  a_r1_mode_from_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ready) |-> remap_mode[0] == $past(boot_pin0) &&
                         remap_mode[1] == ($past(boot_pin0) & $past(boot_pin1)));
  a_r3_standby_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit |=> !cpu_ready);
  a_r5_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && remap_we && !standby_exit |=> remap_mode == $past(remap_wdata));
  a_r5_write_ignored_early: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready && !$rose(cpu_ready) |-> $stable(remap_mode));
  a_r10_passthrough_high: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[31:WIN_BITS+1] != '0 |-> phys_addr == cpu_addr);
  a_r11_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_ready && cpu_valid);
endmodule

// File: tb/boot_remap_decoder_tb_top.sv
module boot_remap_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin0 = 1'b0, boot_pin1 = 1'b0, standby_exit = 1'b0;
  logic        remap_we = 1'b0;
  logic [1:0]  remap_wdata = 2'b00;
  logic        cpu_valid = 1'b0;
  logic [31:0] cpu_addr = 32'h0;
  logic        pin1_released, cpu_ready, cpu_err;
  logic [1:0]  remap_mode;
  logic [31:0] phys_addr;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_remap_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .boot_pin0(boot_pin0), .boot_pin1(boot_pin1),
    .standby_exit(standby_exit), .pin1_released(pin1_released),
    .remap_we(remap_we), .remap_wdata(remap_wdata), .remap_mode(remap_mode),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .phys_addr(phys_addr), .cpu_err(cpu_err));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] m, input logic [31:0] a,
                                output logic [31:0] p, output bit e);
    logic [31:0] off, base, size;
    off = a % 32'h0400_0000;
    case (m)
      2'b00: begin base = 32'h0800_0000; size = 32'h0010_0000; end
      2'b01: begin base = 32'h1FFF_0000; size = 32'h0000_7800; end
      2'b11: begin base = 32'h2000_0000; size = 32'h0001_C000; end
      default: begin base = 32'h6000_0000; size = 32'h0400_0000; end
    endcase
    p = a; e = 0;
    if (a < 32'h0400_0000) begin p = base + off; e = off >= size; end
    else if (a < 32'h0800_0000) begin
      if (m == 2'b10) p = 32'h6400_0000 + off; else e = 1;
    end else if (m == 2'b10 && a >= 32'hA000_0000 && a <= 32'hA000_0FFF) e = 1;
  endfunction

  task automatic boot(input logic p0, input logic p1, input bit early_write);
    rst_n = 0; boot_pin0 = p0; boot_pin1 = p1;
    tick(); tick();
    chk(cpu_ready == 0 && pin1_released == 0, "R4 reset state", {30'b0, pin1_released, cpu_ready}, 0);
    rst_n = 1;
    for (int e = 1; e <= 4; e++) begin
      remap_we = early_write && e == 2; remap_wdata = 2'b10;
      tick();
      remap_we = 0;
      chk(cpu_ready == (e >= 4), "R2 capture edge", {31'b0, cpu_ready}, {31'b0, e >= 4});
      chk(pin1_released == (e >= 4), "R4 pin release", {31'b0, pin1_released}, {31'b0, e >= 4});
    end
    chk(remap_mode == {p1 & p0, p0}, early_write ? "R5 early write ignored" : "R1 pin decode",
        {30'b0, remap_mode}, {30'b0, p1 & p0, p0});
  endtask

  task automatic set_mode(input logic [1:0] m);
    remap_we = 1; remap_wdata = m; tick(); remap_we = 0;
    chk(remap_mode == m, "R5 remap write", {30'b0, remap_mode}, {30'b0, m});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] addrs [15];
    logic [31:0] ep;
    bit ee;
    addrs = '{32'h0, 32'h4, 32'h7FFC, 32'h7800, 32'h1BFFC, 32'h1C000,
              32'hFFFFC, 32'h10_0000, 32'h03FF_FFFC, 32'h0400_0000,
              32'h07FF_FFFC, 32'h0800_0010, 32'h2000_0100, 32'hA000_0FFC, 32'hA000_1000};

    boot(0, 1, 0);
    boot(1, 0, 0);
    boot(1, 1, 0);
    boot(0, 0, 1);
    boot_pin0 = 1; boot_pin1 = 1; tick(); tick();
    chk(remap_mode == 2'b00, "R2 later pin change ignored", {30'b0, remap_mode}, 0);

    cpu_valid = 1;
    for (int mi = 0; mi < 4; mi++) begin
      set_mode(2'(mi));
      for (int i = 0; i < 15; i++) begin
        cpu_addr = addrs[i]; #1;
        model(2'(mi), addrs[i], ep, ee);
        chk(phys_addr == ep, "R6 R7 R10 translation", phys_addr, ep);
        chk(cpu_err == ee, "R7 R8 R9 error response", {31'b0, cpu_err}, {31'b0, ee});
      end
    end

    cpu_addr = 32'h0400_0000; cpu_valid = 0; set_mode(2'b00); #1;
    chk(cpu_err == 0, "R11 no error without valid", {31'b0, cpu_err}, 0);

    cpu_valid = 1; cpu_addr = 32'h0010_0000;
    set_mode(2'b10); #1;
    model(2'b10, cpu_addr, ep, ee);
    chk(phys_addr == ep && cpu_err == 0, "R5 effective next transfer", phys_addr, ep);

    boot_pin0 = 1; boot_pin1 = 1;
    standby_exit = 1; tick(); standby_exit = 0;
    chk(cpu_ready == 0 && pin1_released == 0, "R3 standby drops ready", {30'b0, pin1_released, cpu_ready}, 0);
    chk(cpu_err == 0, "R11 no error while not ready", {31'b0, cpu_err}, 0);
    for (int e = 1; e <= 4; e++) begin
      tick();
      chk(cpu_ready == (e >= 4), "R3 resample edge", {31'b0, cpu_ready}, {31'b0, e >= 4});
    end
    chk(remap_mode == 2'b11, "R3 resampled mode", {30'b0, remap_mode}, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule